// File: doc/BRIEF.md
# SPI Serial EEPROM Responder

This block stands in for a byte-addressed serial EEPROM on an SPI bus, in SPI mode 0. It oversamples the bus lines with the system clock, gathers each command byte, and serves status reads, array reads and page writes out of an on-chip byte array that block RAM can hold. A host can therefore exercise a real EEPROM driver against synthesizable logic: it sets the write-enable latch, streams a page of data, and then polls the ready bit until the internal write cycle is over.

Written bytes go into a page buffer. They reach the array only after chip-select is released, during a busy interval whose length is a parameter. During that interval the status register reports the write in progress and holds the latch set. Block-protect bits fence off the top quarter, the top half or the whole array. A hardware write-protect input, together with a protect-enable bit in the status register, freezes the status register.

Top module: `spi_eeprom_resp`

## Requirements
- R1: After reset the status register reads 0x00 and spi_miso is 0.
- R2: Opcode 0x06 sets the write-enable latch and 0x04 clears it. Opcode 0x05 returns the status byte on every following byte of the frame, with bit 0 = busy, bit 1 = write-enable latch, bits 3:2 = block-protect and bit 7 = protect-enable. All other bits read as 0.
- R3: Opcode 0x03 takes the address most significant byte first. It then shifts array bytes out MSB first, and each bit changes on a falling SCK edge. The address counts up across page boundaries and wraps from the last byte of the array to byte 0.
- R4: With opcode addressing enabled (the default: one address byte, 512-byte array), bit 3 of a read or write opcode is address bit 8. So 0x0B reads and 0x0A writes the upper 256 bytes.
- R5: A write (0x02/0x0A) or a status write (0x01) is ignored when the write-enable latch is clear. No busy interval starts and the array is unchanged.
- R6: Write data lands at successive addresses within one page of PAGE_BYTES (default 16). Bytes past the page end overwrite the start of the same page and never touch the next page. The array is updated only after spi_csn rises.
- R7: From the release of a write frame, status bit 0 reads 1 for max(BUSY_CYCLES, PAGE_BYTES) clock cycles, with bit 1 still set. Bits 0 and 1 then fall in the same cycle, so no status byte ever shows them differing.
- R8: While busy, only opcode 0x05 is honoured. A read returns 0x00 bytes, and a 0x04 leaves the latch set.
- R9: A status write takes bits 7, 3 and 2 from the data byte, starts a busy interval, and clears the latch when that interval ends.
- R10: Block-protect 1, 2 or 3 makes addresses with bits 8:7 equal to 11, with bit 8 set, or anywhere read-only. A write to a protected page is discarded without a busy interval, and the latch is cleared at once.
- R11: While protect-enable is 1 and wp_n is low, a status write is ignored and the latch is left set.
- R12: spi_miso is 0 whenever spi_csn is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the SPI lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock from the host, idle low |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the host |
| wp_n | input | 1 | Active-low hardware write-protect for the status register |
| spi_miso | output | 1 | Serial data to the host, registered |

## Verification
Two events can land in the same cycle: the end of the internal write cycle, which clears busy and the write-enable latch, and the loading of a status byte into the shifter during polling. The bench provokes this by polling with a single long status-read frame that spans the whole busy interval, so the moment busy ends falls somewhere inside a status byte. Every status byte returned is judged on one point: bit 0 and bit 1 must be equal. A value of 0x01 or 0x02 shows a torn update.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_WRSR  = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;

  typedef enum logic [2:0] {
    PH_OPC,
    PH_ADDR,
    PH_RDATA,
    PH_WDATA,
    PH_STAT,
    PH_SWR,
    PH_SKIP
  } phase_t;

  // Protected-region test: top2 holds the two highest address bits.
  function automatic logic in_locked(input logic [1:0] bp, input logic [1:0] top2);
    logic r;
    case (bp)
      2'd0:    r = 1'b0;
      2'd1:    r = (top2 == 2'b11);
      2'd2:    r = top2[1];
      default: r = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/spi_ee_link.sv
module spi_ee_link (
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       sel_o,
  output logic       frame_end_o,
  output logic       rx_valid_o,
  output logic [7:0] rx_byte_o
);

  logic sck_m, sck_s, sck_d;
  logic csn_m, csn_s, csn_d;
  logic mosi_m, mosi_s;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sr;
  logic [6:0] tx_sr;
  logic       miso_q;

  logic sck_rise, sck_fall, active;
  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign active   = ~csn_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_m  <= 1'b0; sck_s <= 1'b0; sck_d <= 1'b0;
      csn_m  <= 1'b1; csn_s <= 1'b1; csn_d <= 1'b1;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
    end else begin
      sck_m  <= sck_i;  sck_s <= sck_m;  sck_d <= sck_s;
      csn_m  <= csn_i;  csn_s <= csn_m;  csn_d <= csn_s;
      mosi_m <= mosi_i; mosi_s <= mosi_m;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt    <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      miso_q     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else if (!active) begin
      bit_cnt    <= '0;
      tx_sr      <= '0;
      miso_q     <= 1'b0;
      rx_valid_o <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      if (sck_rise) begin
        rx_sr   <= {rx_sr[5:0], mosi_s};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          rx_valid_o <= 1'b1;
          rx_byte_o  <= {rx_sr, mosi_s};
        end
      end
      if (sck_fall) begin
        if (bit_cnt == 3'd0) begin
          miso_q <= tx_byte_i[7];
          tx_sr  <= tx_byte_i[6:0];
        end else begin
          miso_q <= tx_sr[6];
          tx_sr  <= {tx_sr[5:0], 1'b0};
        end
      end
    end
  end

  assign miso_o      = miso_q;
  assign sel_o       = active;
  assign frame_end_o = csn_s & ~csn_d;

  // R12
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> !miso_o);

endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int ADDR_BYTES   = 1,
  parameter int OPC_ADDR_BIT = 1,
  parameter int PAGE_BYTES   = 16,
  parameter int HOLD         = 600,
  parameter int LOW_W        = ADDR_BYTES * 8,
  parameter int AW           = LOW_W + OPC_ADDR_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_end,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          wp_n,
  input  logic [7:0]    rd_data,
  output logic [7:0]    tx_byte,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data
);

  localparam int PW = $clog2(PAGE_BYTES);
  localparam int HW = $clog2(HOLD);
  localparam logic [PW:0]   PAGE_N  = (PW+1)'(PAGE_BYTES);
  localparam logic [HW-1:0] HOLD_M1 = HW'(HOLD - 1);
  localparam logic [1:0]    ALAST   = 2'(ADDR_BYTES - 1);
  localparam logic [7:0]    RW_MASK = (OPC_ADDR_BIT != 0) ? 8'hF7 : 8'hFF;

  phase_t            phase;
  logic              opc_hi;
  logic [1:0]        acnt;
  logic              is_write;
  logic [AW-1:0]     rd_addr_q;
  logic [AW-PW-1:0]  wbase;
  logic [PW-1:0]     woff;
  logic [PAGE_BYTES-1:0] pval;
  logic [7:0]        pbuf [PAGE_BYTES];
  logic              wany;
  logic [1:0]        sr_bp_new;
  logic              sr_wp_new;
  logic              sr_pend;
  logic              wel, busy, wpen;
  logic [1:0]        bp;
  logic [HW-1:0]     hold_cnt;
  logic [PW:0]       cidx;
  logic              commit_data;

  logic [LOW_W-1:0]  lo_nx;
  logic [AW-1:0]     full_nx;
  logic              hit_read, hit_write, wrsr_ok;
  logic [7:0]        status;

  generate
    if (LOW_W > 8) begin : g_multi_addr
      logic [LOW_W-9:0] lo_hist;
      always_ff @(posedge clk) begin
        if (rst) lo_hist <= '0;
        else if (rx_valid && phase == PH_ADDR) lo_hist <= lo_nx[LOW_W-9:0];
      end
      assign lo_nx = {lo_hist, rx_byte};
    end else begin : g_single_addr
      assign lo_nx = rx_byte;
    end

    if (OPC_ADDR_BIT != 0) begin : g_opc_bit
      assign full_nx = {opc_hi, lo_nx};
    end else begin : g_no_opc_bit
      assign full_nx = lo_nx;
    end
  endgenerate

  assign hit_read  = ((rx_byte & RW_MASK) == OP_READ);
  assign hit_write = ((rx_byte & RW_MASK) == OP_WRITE);
  assign wrsr_ok   = wel && !(wpen && !wp_n);
  assign status    = {wpen, 3'b000, bp, wel, busy};

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_OPC;
      opc_hi      <= 1'b0;
      acnt        <= '0;
      is_write    <= 1'b0;
      rd_addr_q   <= '0;
      wbase       <= '0;
      woff        <= '0;
      pval        <= '0;
      wany        <= 1'b0;
      sr_bp_new   <= '0;
      sr_wp_new   <= 1'b0;
      sr_pend     <= 1'b0;
      wel         <= 1'b0;
      busy        <= 1'b0;
      wpen        <= 1'b0;
      bp          <= '0;
      hold_cnt    <= '0;
      cidx        <= '0;
      commit_data <= 1'b0;
    end else begin
      // internal write cycle
      if (busy) begin
        if (cidx != PAGE_N) cidx <= cidx + 1'b1;
        if (hold_cnt == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else begin
          hold_cnt <= hold_cnt - 1'b1;
        end
      end

      if (frame_end) begin
        phase <= PH_OPC;
        if (phase == PH_WDATA) begin
          if (wany && !in_locked(bp, wbase[AW-PW-1 -: 2])) begin
            busy        <= 1'b1;
            hold_cnt    <= HOLD_M1;
            cidx        <= '0;
            commit_data <= 1'b1;
          end else begin
            wel <= 1'b0;
          end
        end else if (phase == PH_SWR) begin
          if (sr_pend) begin
            bp          <= sr_bp_new;
            wpen        <= sr_wp_new;
            busy        <= 1'b1;
            hold_cnt    <= HOLD_M1;
            cidx        <= PAGE_N;
            commit_data <= 1'b0;
          end else begin
            wel <= 1'b0;
          end
          sr_pend <= 1'b0;
        end
      end else if (rx_valid) begin
        case (phase)
          PH_OPC: begin
            if (busy) begin
              phase <= (rx_byte == OP_RDSR) ? PH_STAT : PH_SKIP;
            end else if (rx_byte == OP_WREN) begin
              wel   <= 1'b1;
              phase <= PH_SKIP;
            end else if (rx_byte == OP_WRDI) begin
              wel   <= 1'b0;
              phase <= PH_SKIP;
            end else if (rx_byte == OP_RDSR) begin
              phase <= PH_STAT;
            end else if (rx_byte == OP_WRSR) begin
              phase <= wrsr_ok ? PH_SWR : PH_SKIP;
            end else if (hit_read) begin
              opc_hi   <= rx_byte[3];
              is_write <= 1'b0;
              acnt     <= '0;
              phase    <= PH_ADDR;
            end else if (hit_write && wel) begin
              opc_hi   <= rx_byte[3];
              is_write <= 1'b1;
              acnt     <= '0;
              phase    <= PH_ADDR;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_ADDR: begin
            acnt <= acnt + 2'd1;
            if (acnt == ALAST) begin
              if (is_write) begin
                wbase <= full_nx[AW-1:PW];
                woff  <= full_nx[PW-1:0];
                pval  <= '0;
                wany  <= 1'b0;
                phase <= PH_WDATA;
              end else begin
                rd_addr_q <= full_nx;
                phase     <= PH_RDATA;
              end
            end
          end
          PH_RDATA: rd_addr_q <= rd_addr_q + 1'b1;
          PH_WDATA: begin
            pval[woff] <= 1'b1;
            woff       <= woff + 1'b1;
            wany       <= 1'b1;
          end
          PH_SWR: begin
            sr_bp_new <= rx_byte[3:2];
            sr_wp_new <= rx_byte[7];
            sr_pend   <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // page buffer storage, no reset needed
  always_ff @(posedge clk) begin
    if (rx_valid && !frame_end && phase == PH_WDATA) pbuf[woff] <= rx_byte;
  end

  always_comb begin
    case (phase)
      PH_STAT:  tx_byte = status;
      PH_RDATA: tx_byte = rd_data;
      default:  tx_byte = 8'h00;
    endcase
  end

  assign rd_addr = rd_addr_q;
  assign wr_en   = busy && commit_data && !cidx[PW] && pval[cidx[PW-1:0]];
  assign wr_addr = {wbase, cidx[PW-1:0]};
  assign wr_data = pbuf[cidx[PW-1:0]];

  // R7
  busy_holds_wel_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> wel);

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R2
  wel_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(rx_valid && phase == PH_OPC && rx_byte == OP_WREN));

  // R10
  locked_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !in_locked(bp, wr_addr[AW-1 -: 2]));

  // R8
  busy_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && rx_valid && phase == PH_OPC && rx_byte != OP_RDSR) |=> phase == PH_SKIP);

endmodule

// File: rtl/spi_eeprom_resp.sv
module spi_eeprom_resp #(
  parameter int ADDR_BYTES   = 1,
  parameter int OPC_ADDR_BIT = 1,
  parameter int PAGE_BYTES   = 16,
  parameter int BUSY_CYCLES  = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sck,
  input  logic spi_csn,
  input  logic spi_mosi,
  input  logic wp_n,
  output logic spi_miso
);

  localparam int LOW_W = ADDR_BYTES * 8;
  localparam int AW    = LOW_W + OPC_ADDR_BIT;
  localparam int HOLD  = (BUSY_CYCLES > PAGE_BYTES) ? BUSY_CYCLES : PAGE_BYTES;

  logic          sel, frame_end, rx_valid;
  logic [7:0]    rx_byte, tx_byte, rd_data, wr_data;
  logic [AW-1:0] rd_addr, wr_addr;
  logic          wr_en;

  spi_ee_link u_link (
    .clk         (clk),
    .rst         (rst),
    .sck_i       (spi_sck),
    .csn_i       (spi_csn),
    .mosi_i      (spi_mosi),
    .tx_byte_i   (tx_byte),
    .miso_o      (spi_miso),
    .sel_o       (sel),
    .frame_end_o (frame_end),
    .rx_valid_o  (rx_valid),
    .rx_byte_o   (rx_byte)
  );

  spi_ee_ctrl #(
    .ADDR_BYTES   (ADDR_BYTES),
    .OPC_ADDR_BIT (OPC_ADDR_BIT),
    .PAGE_BYTES   (PAGE_BYTES),
    .HOLD         (HOLD),
    .LOW_W        (LOW_W),
    .AW           (AW)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .frame_end (frame_end),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .wp_n      (wp_n),
    .rd_data   (rd_data),
    .tx_byte   (tx_byte),
    .rd_addr   (rd_addr),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data)
  );

  spi_ee_array #(.AW(AW)) u_array (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // R3
  rx_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> sel);

endmodule

// File: tb/spi_eeprom_resp_bench.sv
module spi_eeprom_resp_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0;
  logic spi_csn = 1'b1;
  logic spi_mosi = 1'b0;
  logic wp_n = 1'b1;
  logic spi_miso;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  spi_eeprom_resp u_spi_eeprom_resp (
    .clk      (clk),
    .rst      (rst),
    .spi_sck  (spi_sck),
    .spi_csn  (spi_csn),
    .spi_mosi (spi_mosi),
    .wp_n     (wp_n),
    .spi_miso (spi_miso)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (6) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tx[i];
      half();
      rx[i] = spi_miso;
      spi_sck = 1'b1;
      half();
      spi_sck = 1'b0;
    end
  endtask

  task automatic fbegin();
    spi_csn = 1'b0;
    half();
  endtask

  task automatic fend();
    half();
    spi_csn = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    fbegin(); xfer(op, d); fend();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    fbegin(); xfer(8'h05, d); xfer(8'h00, st); fend();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] d;
    fbegin(); xfer(8'h01, d); xfer(v, d); fend();
  endtask

  task automatic wr(input logic [7:0] op, input logic [7:0] a, input int n, input logic [7:0] dat [8]);
    logic [7:0] d;
    fbegin(); xfer(op, d); xfer(a, d);
    for (int i = 0; i < n; i++) xfer(dat[i], d);
    fend();
  endtask

  task automatic rd(input logic [7:0] op, input logic [7:0] a, input int n, output logic [7:0] dat [8]);
    logic [7:0] d;
    fbegin(); xfer(op, d); xfer(a, d);
    for (int i = 0; i < 8; i++) dat[i] = 8'h00;
    for (int i = 0; i < n; i++) xfer(8'h00, dat[i]);
    fend();
  endtask

  // one long status frame across the whole busy interval
  task automatic wait_ready(input string req);
    logic [7:0] d, st;
    bit ready = 1'b0;
    fbegin(); xfer(8'h05, d);
    for (int i = 0; i < 60 && !ready; i++) begin
      xfer(8'h00, st);
      chk({req, " R7 busy/latch agree"}, {7'b0, st[0]}, {7'b0, st[1]});
      if (!st[0]) ready = 1'b1;
    end
    fend();
    chk({req, " R7 ready reached"}, {7'b0, ready}, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] st;
    chk("R1 miso after reset", {7'b0, spi_miso}, 8'h00);
    rdsr(st);
    chk("R1 status after reset", st, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] st, d, s2;
    cmd1(8'h06);
    rdsr(st);
    chk("R2 latch set", st, 8'h02);
    fbegin(); xfer(8'h05, d); xfer(8'h00, st); xfer(8'h00, s2); fend();
    chk("R2 status repeat 1", st, 8'h02);
    chk("R2 status repeat 2", s2, 8'h02);
    cmd1(8'h04);
    rdsr(st);
    chk("R2 latch cleared", st, 8'h00);
  endtask

  task automatic t_write_basic();
    logic [7:0] w [8], r [8], st;
    w = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06);
    wr(8'h02, 8'h10, 4, w);
    rdsr(st);
    chk("R7 busy after write", st, 8'h03);
    wait_ready("basic");
    rdsr(st);
    chk("R7 idle after write", st, 8'h00);
    rd(8'h03, 8'h10, 4, r);
    for (int i = 0; i < 4; i++) chk("R3 read back", r[i], w[i]);
  endtask

  task automatic t_page_wrap();
    logic [7:0] w [8], r [8];
    w = '{8'h5A, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h02, 8'h40, 1, w); wait_ready("pre");
    w = '{8'hA0, 8'hA1, 8'hA2, 8'hA3, 8'hA4, 8'hA5, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h02, 8'h3C, 6, w); wait_ready("wrap");
    rd(8'h03, 8'h3C, 5, r);
    chk("R6 wrap 3C", r[0], 8'hA0);
    chk("R6 wrap 3F", r[3], 8'hA3);
    chk("R3 R6 next page untouched", r[4], 8'h5A);
    rd(8'h03, 8'h30, 2, r);
    chk("R6 page start 30", r[0], 8'hA4);
    chk("R6 page start 31", r[1], 8'hA5);
  endtask

  task automatic t_opc_bit();
    logic [7:0] w [8], r [8];
    w = '{8'h77, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h0A, 8'h10, 1, w); wait_ready("hi");
    rd(8'h03, 8'h10, 1, r);
    chk("R4 low half intact", r[0], 8'h11);
    rd(8'h0B, 8'h10, 1, r);
    chk("R4 upper half", r[0], 8'h77);
  endtask

  task automatic t_array_wrap();
    logic [7:0] w [8], r [8];
    w = '{8'hEE, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h0A, 8'hFF, 1, w); wait_ready("top");
    w = '{8'hD0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h02, 8'h00, 1, w); wait_ready("zero");
    w = '{8'h12, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h0A, 8'hF0, 1, w); wait_ready("f0");
    rd(8'h0B, 8'hFF, 2, r);
    chk("R3 last byte", r[0], 8'hEE);
    chk("R3 wrap to 0", r[1], 8'hD0);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] w [8], r [8], st;
    w = '{8'h99, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h02, 8'h50, 1, w);
    rd(8'h03, 8'h10, 1, r);
    chk("R8 read during busy", r[0], 8'h00);
    cmd1(8'h04);
    rdsr(st);
    chk("R8 clear ignored while busy", st, 8'h03);
    wait_ready("busy");
    rd(8'h03, 8'h50, 1, r);
    chk("R8 write landed", r[0], 8'h99);
  endtask

  task automatic t_no_latch();
    logic [7:0] w [8], r [8], st;
    w = '{8'hFF, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    wr(8'h02, 8'h10, 1, w);
    rdsr(st);
    chk("R5 no busy without latch", st, 8'h00);
    rd(8'h03, 8'h10, 1, r);
    chk("R5 array unchanged", r[0], 8'h11);
    wrsr(8'h0C);
    rdsr(st);
    chk("R5 status write ignored", st, 8'h00);
  endtask

  task automatic t_protect();
    logic [7:0] w [8], r [8], st;
    cmd1(8'h06); wrsr(8'h04);
    rdsr(st);
    chk("R9 status write busy", st, 8'h07);
    wait_ready("sr");
    rdsr(st);
    chk("R9 protect bits set", st, 8'h04);
    w = '{8'h33, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h0A, 8'hF0, 1, w);
    rdsr(st);
    chk("R10 locked: no busy, latch clear", st, 8'h04);
    rd(8'h0B, 8'hF0, 1, r);
    chk("R10 locked byte kept", r[0], 8'h12);
    w = '{8'h44, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h0A, 8'h00, 1, w);
    rdsr(st);
    chk("R10 unlocked region busy", st, 8'h07);
    wait_ready("unl");
    rd(8'h0B, 8'h00, 1, r);
    chk("R10 unlocked write", r[0], 8'h44);
    cmd1(8'h06); wrsr(8'h0C); wait_ready("all");
    cmd1(8'h06); wr(8'h02, 8'h10, 1, w);
    rdsr(st);
    chk("R10 whole array locked", st, 8'h0C);
    rd(8'h03, 8'h10, 1, r);
    chk("R10 low byte kept", r[0], 8'h11);
  endtask

  task automatic t_wp_pin();
    logic [7:0] st;
    cmd1(8'h06); wrsr(8'h8C); wait_ready("wpen");
    rdsr(st);
    chk("R9 enable bit stored", st, 8'h8C);
    wp_n = 1'b0;
    cmd1(8'h06); wrsr(8'h00);
    rdsr(st);
    chk("R11 status frozen", st, 8'h8E);
    wp_n = 1'b1;
    wrsr(8'h00); wait_ready("unfrz");
    rdsr(st);
    chk("R11 pin released", st, 8'h00);
  endtask

  task automatic t_idle_miso();
    logic [7:0] w [8], r [8];
    w = '{8'hFF, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0, 8'h0};
    cmd1(8'h06); wr(8'h02, 8'h60, 1, w); wait_ready("ff");
    rd(8'h03, 8'h60, 1, r);
    chk("R3 all ones byte", r[0], 8'hFF);
    for (int i = 0; i < 3; i++) begin
      repeat (5) @(negedge clk);
      chk("R12 miso idle", {7'b0, spi_miso}, 8'h00);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_latch();
    t_write_basic();
    t_page_wrap();
    t_opc_bit();
    t_array_wrap();
    t_busy_ignore();
    t_no_latch();
    t_protect();
    t_wp_pin();
    t_idle_miso();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule